// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block turns a fast reference clock into the serial clock of an SPI master. Software writes a configuration byte that selects the divide ratio. A mode input chooses how that byte is read. The legacy encoding gives even divisors from 4 to 30. The extended encoding gives a 4-bit scaler shifted left by a 3-bit pre-scaler, and covers divisors from 1 to 1920.

The block decodes the byte and raises a flag when a setting cannot be used. It runs a period counter that drives a registered SCK, whose idle level follows a polarity input. It also gives a one-cycle divided clock enable at the end of each SCK period, for the shift logic next to it. A run input starts and stops the clock. A new ratio, and a stop, take effect only at the end of the current period, so SCK never shows a shortened pulse.

Top module: `sck_clock_divider`

## Requirements
- R1: In legacy mode (`ext_mode`=0) the block uses only `cfg_byte[4:0]`. The setting is valid only when bit 4 is 1 and the value h=`cfg_byte[3:0]` is at least 2. The divisor is then 2·h, which gives 4 to 30. Bits 7:5 have no effect.
- R2: In extended mode (`ext_mode`=1) the scaler is s=`cfg_byte[3:0]`. The pre-scaler is p={`cfg_byte[7]`,`cfg_byte[6]`,`cfg_byte[4]`}, with `cfg_byte[4]` as its least significant bit. The divisor is s·2^p. Bit 5 has no effect.
- R3: In extended mode a scaler of 0 is an invalid setting.
- R4: `cfg_bad` is 1 exactly when the present `cfg_byte` and `ext_mode` form an invalid setting. It responds combinationally. With an invalid setting, asserting `run` never starts SCK: SCK stays at the idle level and `sck_tick` stays 0.
- R5: An SCK period with divisor d lasts d reference cycles. It opens with floor(d/2) cycles at the active level and ends with ceil(d/2) cycles at the idle level. For odd d the active phase is therefore one cycle shorter. With d=1 SCK stays idle and only `sck_tick` pulses.
- R6: `sck_tick` is high for exactly one reference cycle, the last cycle of each SCK period. It is 0 at all other times.
- R7: The idle level of SCK equals `cpol` and the active level equals the inverse of `cpol`.
- R8: When `run` and a valid setting are both present at a clock edge while the clock is stopped, the first period begins at that edge.
- R9: When `run` is low at the end of a period, SCK returns to idle and stays there, with no further ticks. A period already started is always completed.
- R10: A changed setting is taken only at the end of a period. If the setting is invalid at that point, the clock stops there.
- R11: During reset SCK equals `cpol` and `sck_tick` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_byte | input | 8 | Divide-ratio configuration byte |
| ext_mode | input | 1 | 0 = legacy even-divisor encoding, 1 = extended scaler/pre-scaler encoding |
| cpol | input | 1 | SCK idle level |
| run | input | 1 | Clock request; starts and stops at period boundaries |
| sck | output | 1 | Serial clock |
| sck_tick | output | 1 | One-cycle enable on the last reference cycle of each SCK period |
| cfg_bad | output | 1 | Present setting is invalid |

## Verification
The bench builds the block with its default widths: a 4-bit scaler, a 3-bit pre-scaler and an 11-bit period counter. These reach both ends of the extended range. Divide-by-1 exercises the degenerate period, and 1920 (all ones) runs the counter to its highest count. Odd divisors, the scattered pre-scaler bits, and the ignored bits with both polarities are all covered. So are reload and stop at a period boundary, including a switch to an invalid setting while running.

// File: rtl/sck_div_pkg.sv
`timescale 1ns/1ps
package sck_div_pkg;
  localparam int CFG_W = 8;
  localparam int SCL_W = 4;
  localparam int PRE_W = 3;
  localparam int DIV_W = SCL_W + (1 << PRE_W) - 1;

  typedef enum logic {
    MODE_LEGACY   = 1'b0,
    MODE_EXTENDED = 1'b1
  } div_mode_e;
endpackage

// File: rtl/sck_rst_sync.sv
`timescale 1ns/1ps
module sck_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_n;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/sck_cfg_decode.sv
`timescale 1ns/1ps
module sck_cfg_decode
  import sck_div_pkg::*;
#(
  parameter int SCALER_W = SCL_W,
  parameter int PRESC_W  = PRE_W,
  parameter int CNT_W    = DIV_W
) (
  input  logic [CFG_W-1:0] cfg,
  input  div_mode_e        mode,
  output logic             ok,
  output logic [CNT_W-1:0] div
);
  // field positions are fixed by the register layout the shift logic shares
  localparam int PRE_LO_BIT = SCALER_W;
  localparam int PRE_HI_LSB = SCALER_W + 2;
  localparam int LEG_MIN_H  = 2;

  logic [SCALER_W-1:0] ext_scl;
  logic [PRESC_W-1:0]  ext_pre;
  logic [CNT_W-1:0]    ext_div;
  logic                ext_ok;
  logic [SCALER_W-1:0] leg_half;
  logic [CNT_W-1:0]    leg_div;
  logic                leg_ok;
  logic                cfg_unused;

  assign cfg_unused = cfg[SCALER_W+1];

  always_comb begin
    ext_scl = cfg[SCALER_W-1:0];
    ext_pre = {cfg[PRE_HI_LSB+1:PRE_HI_LSB], cfg[PRE_LO_BIT]};
    ext_div = CNT_W'(ext_scl) << ext_pre;
    ext_ok  = (ext_scl != '0);
  end

  always_comb begin
    leg_half = cfg[SCALER_W-1:0];
    leg_div  = CNT_W'({leg_half, 1'b0});
    leg_ok   = cfg[PRE_LO_BIT] && (leg_half >= SCALER_W'(LEG_MIN_H));
  end

  always_comb begin
    if (mode == MODE_EXTENDED) begin
      ok  = ext_ok;
      div = ext_div;
    end else begin
      ok  = leg_ok;
      div = leg_div;
    end
  end

  // R3
  always_comb begin
    ok_div_nonzero_chk: assert (!ok || (div != '0));
  end
endmodule

// File: rtl/sck_phase_gen.sv
`timescale 1ns/1ps
module sck_phase_gen
  import sck_div_pkg::*;
#(
  parameter int CNT_W = DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cfg_ok,
  input  logic [CNT_W-1:0] cfg_div,
  output logic             act_q,
  output logic             tick_q
);
  logic             live_q, live_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] div_q, div_n;
  logic             act_n, tick_n;
  logic             last;
  logic             go;
  logic             clk_en;

  always_comb begin
    last   = live_q && (cnt_q == (div_q - 1'b1));
    go     = run && cfg_ok;
    clk_en = live_q || run;
    live_n = live_q;
    cnt_n  = cnt_q;
    div_n  = div_q;
    if (!live_q) begin
      if (go) begin
        live_n = 1'b1;
        cnt_n  = '0;
        div_n  = cfg_div;
      end
    end else if (last) begin
      cnt_n = '0;
      if (go) begin
        div_n = cfg_div;
      end else begin
        live_n = 1'b0;
      end
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
    act_n  = live_n && (cnt_n < (div_n >> 1));
    tick_n = live_n && (cnt_n == (div_n - 1'b1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      cnt_q  <= '0;
      div_q  <= '0;
      act_q  <= 1'b0;
      tick_q <= 1'b0;
    end else if (clk_en) begin
      live_q <= live_n;
      cnt_q  <= cnt_n;
      div_q  <= div_n;
      act_q  <= act_n;
      tick_q <= tick_n;
    end
  end

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !live_q |-> (!act_q && !tick_q));

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (cnt_q < div_q));

  // R10
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(live_q) && !$past(tick_q)) |-> $stable(div_q));

  // R4
  bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!live_q && !cfg_ok) |=> !live_q);

  // R6
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && live_q) |=> (!live_q || (cnt_q == '0)));
endmodule

// File: rtl/sck_clock_divider.sv
`timescale 1ns/1ps
module sck_clock_divider
  import sck_div_pkg::*;
#(
  parameter int SCALER_W   = SCL_W,
  parameter int PRESC_W    = PRE_W,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_byte,
  input  logic             ext_mode,
  input  logic             cpol,
  input  logic             run,
  output logic             sck,
  output logic             sck_tick,
  output logic             cfg_bad
);
  localparam int CNT_W = SCALER_W + (1 << PRESC_W) - 1;

  logic             srst_n;
  logic             dec_ok;
  logic [CNT_W-1:0] dec_div;
  logic             act_q;
  div_mode_e        mode;

  assign mode = div_mode_e'(ext_mode);

  sck_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk    (clk_ref),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sck_cfg_decode #(
    .SCALER_W (SCALER_W),
    .PRESC_W  (PRESC_W),
    .CNT_W    (CNT_W)
  ) u_dec (
    .cfg  (cfg_byte),
    .mode (mode),
    .ok   (dec_ok),
    .div  (dec_div)
  );

  sck_phase_gen #(.CNT_W(CNT_W)) u_gen (
    .clk     (clk_ref),
    .rst_n   (srst_n),
    .run     (run),
    .cfg_ok  (dec_ok),
    .cfg_div (dec_div),
    .act_q   (act_q),
    .tick_q  (sck_tick)
  );

  assign sck     = act_q ^ cpol;
  assign cfg_bad = !dec_ok;
endmodule

// File: tb/sim_sck_clock_divider.sv
`timescale 1ns/1ps
module sim_sck_clock_divider;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cfg_byte;
  logic       ext_mode;
  logic       cpol;
  logic       run;
  logic       sck;
  logic       sck_tick;
  logic       cfg_bad;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  sck;
    logic  tick;
    string req;
  } exp_t;

  exp_t q[$];

  always #4 clk = ~clk;

  sck_clock_divider u0 (
    .clk_ref  (clk_ref_w),
    .rst_n    (rst_n),
    .cfg_byte (cfg_byte),
    .ext_mode (ext_mode),
    .cpol     (cpol),
    .run      (run),
    .sck      (sck),
    .sck_tick (sck_tick),
    .cfg_bad  (cfg_bad)
  );
  wire clk_ref_w = clk;

  task automatic chk(input bit good, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected divisor from R1/R2/R3, 0 when the setting is invalid
  function automatic int exp_div(input logic [7:0] c, input logic m);
    int s;
    int p;
    s = int'(c[3:0]);
    p = int'({c[7:6], c[4]});
    if (m) return (s == 0) ? 0 : (s << p);
    return (c[4] && s >= 2) ? 2 * s : 0;
  endfunction

  task automatic push_period(input int d, input logic pol, input string req);
    for (int k = 0; k < d; k++) begin
      exp_t e;
      e.sck  = pol ^ (k < d / 2);
      e.tick = (k == d - 1);
      e.req  = req;
      q.push_back(e);
    end
  endtask

  task automatic push_idle(input int n, input logic pol, input string req);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.sck  = pol;
      e.tick = 1'b0;
      e.req  = req;
      q.push_back(e);
    end
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: compare one expected item per reference cycle
  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      chk({sck, sck_tick} === {e.sck, e.tick}, e.req, "sck/tick",
          int'({sck, sck_tick}), int'({e.sck, e.tick}));
    end
  end

  // start with cfg_a, switch to cfg_b inside the first period, run P periods of b
  task automatic run_case(input logic [7:0] cfg_a, input logic [7:0] cfg_b,
                          input logic m, input logic pol, input int P,
                          input string req);
    int da;
    int db;
    da = exp_div(cfg_a, m);
    db = exp_div(cfg_b, m);
    @(negedge clk);
    cfg_byte = cfg_a;
    ext_mode = m;
    cpol     = pol;
    run      = 1'b1;
    #1;
    chk(cfg_bad === 1'b0, "R4", "cfg_bad on valid setting", int'(cfg_bad), 0);
    @(posedge clk);
    push_period(da, pol, req);
    if (db != 0) begin
      for (int p = 0; p < P; p++) push_period(db, pol, req);
    end
    push_idle(3, pol, (db != 0) ? "R9" : "R10");
    @(negedge clk);
    cfg_byte = cfg_b;
    #1;
    chk(cfg_bad === (db == 0), "R4", "cfg_bad after change", int'(cfg_bad), int'(db == 0));
    if (db != 0) repeat (da + (P - 1) * db) @(negedge clk);
    else         repeat (da) @(negedge clk);
    run = 1'b0;
    drain();
  endtask

  task automatic bad_case(input logic [7:0] c, input logic m, input logic pol,
                          input string req);
    @(negedge clk);
    cfg_byte = c;
    ext_mode = m;
    cpol     = pol;
    run      = 1'b1;
    #1;
    chk(cfg_bad === 1'b1, req, "cfg_bad on invalid setting", int'(cfg_bad), 1);
    @(posedge clk);
    push_idle(5, pol, "R4");
    drain();
    run = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    cfg_byte = 8'h12;
    ext_mode = 1'b0;
    cpol     = 1'b1;
    run      = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset holds SCK at the idle level with no tick
    chk(sck === 1'b1, "R11", "sck in reset", int'(sck), 1);
    chk(sck_tick === 1'b0, "R11", "tick in reset", int'(sck_tick), 0);
    cpol = 1'b0;
    #1;
    chk(sck === 1'b0, "R11", "sck in reset follows cpol", int'(sck), 0);
    run = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R5 R6 R8: legacy 0x12 -> divisor 4
    run_case(8'h12, 8'h12, 1'b0, 1'b0, 2, "R1 R5 R6 R8");
    // R1 R7: legacy 0xFF, bits 7:5 ignored -> divisor 30, idle high
    run_case(8'hFF, 8'hFF, 1'b0, 1'b1, 2, "R1 R7");
    // R1: legacy half below 2, and bit 4 clear, are invalid
    bad_case(8'h11, 1'b0, 1'b0, "R1");
    bad_case(8'hEF, 1'b0, 1'b1, "R1");
    // R5: extended divide by 1
    run_case(8'h01, 8'h01, 1'b1, 1'b0, 3, "R5");
    // R2 R5: bit 5 ignored, odd divisor 3
    run_case(8'h23, 8'h23, 1'b1, 1'b1, 3, "R2 R5");
    // R2: pre-scaler bit 0 at bit 4 -> 6
    run_case(8'h13, 8'h13, 1'b1, 1'b0, 2, "R2");
    // R2: pre-scaler 2 from bits 7:6 -> 12
    run_case(8'h43, 8'h43, 1'b1, 1'b1, 2, "R2");
    // R2: pre-scaler 7, scaler 5 -> 640
    run_case(8'hD5, 8'hD5, 1'b1, 1'b0, 1, "R2");
    // R2 R7: maximum 1920
    run_case(8'hFF, 8'hFF, 1'b1, 1'b1, 1, "R2 R7");
    // R3: extended scaler 0 invalid
    bad_case(8'hD0, 1'b1, 1'b0, "R3");
    // R10: divisor 2 -> 5 taken at the boundary
    run_case(8'h02, 8'h05, 1'b1, 1'b0, 2, "R10");
    // R10: legacy 8 -> invalid stops at the boundary
    run_case(8'h14, 8'h01, 1'b0, 1'b1, 1, "R10");
    // R9 R8: restart after stop, legacy 6
    run_case(8'h13, 8'h13, 1'b0, 1'b0, 2, "R8 R9");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule